// File: doc/BRIEF.md
# Radix Address Context Selector

This block sits in front of a two-level radix page-table walker and sorts each translation request before any table is read. It takes an effective address, the hypervisor-mode and relocation flags, and the current partition-ID, process-ID and real-mode offset register values. From these it produces one response. The response gives the partition and process IDs that the walker must use, a segment-fault flag, and a real address for requests that bypass translation. It also gives two flags that say whether the process-scoped stage, the partition-scoped stage, or both must run.

The two most significant address bits pick one of four quadrants. Hypervisor mode and guest mode map these quadrants differently. A hypervisor access with relocation off never reaches the walker: the block forms the real address itself and grants full permission.

Requests enter on a valid/ready handshake and leave on a second one, through one register stage. The request side is ready whenever the output register is empty or its content is being taken in the same cycle. While the response is valid and not accepted, every response field holds its value. The walker may stall for any number of cycles and loses nothing.

Top module: `radix_ctx_sel`

## Requirements
- R1: In every request that is not a real-mode bypass, a segment fault is reported when any of address bits [61:52] is set. These are bits 2 to 11 in MSB-first numbering.
- R2: In hypervisor mode the quadrant ea[63:62] selects the IDs as follows. Quadrant 0 gives partition 0 and the current process ID. Quadrant 1 gives the partition register and the current process ID. Quadrant 2 gives the partition register and process 0. Quadrant 3 gives partition 0 and process 0.
- R3: In guest mode, quadrant 0 gives the partition register and the current process ID. Quadrant 3 gives the partition register and process 0.
- R4: In guest mode, quadrants 1 and 2 are reported as a segment fault. Any faulting response carries zero IDs and clears both need flags.
- R5: With hypervisor mode on and relocation off, the response is a bypass. The address is ea with bits [63:60] cleared, and the offset register is ORed in only when ea[63] is 0. Permission is 3'b111 (bit 2 read, bit 1 write, bit 0 execute). There is no fault, IDs are zero and both need flags are clear. All other responses carry permission 3'b000.
- R6: In a request that is neither a bypass nor a fault, the partition-scoped need flag is set when the selected partition ID is nonzero or hypervisor mode is off.
- R7: In a request that is neither a bypass nor a fault, the process-scoped need flag equals the relocation flag. In every request that is not a bypass, the address output is ea with bits [63:52] cleared.
- R8: A request accepted at a clock edge is presented as a valid response right after that edge, one cycle of latency.
- R9: req_ready equals (!rsp_valid || rsp_ready). While rsp_valid is high and rsp_ready is low, the response and all its fields stay unchanged.
- R10: After reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ea | input | EA_W | Effective address |
| req_hv | input | 1 | Hypervisor-mode access |
| req_reloc | input | 1 | Relocation (translation) enabled |
| lpid_reg | input | LPID_W | Current partition-ID register |
| pid_reg | input | PID_W | Current process-ID register |
| rmo_reg | input | EA_W | Real-mode offset register |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_seg_fault | output | 1 | Segment fault |
| rsp_lpid | output | LPID_W | Selected partition ID |
| rsp_pid | output | PID_W | Selected process ID |
| rsp_bypass | output | 1 | Real-mode bypass, no walk |
| rsp_addr | output | EA_W | Bypass real address, or masked effective address |
| rsp_perm | output | 3 | Granted permission {read, write, execute} |
| rsp_need_proc | output | 1 | Process-scoped walk required |
| rsp_need_part | output | 1 | Partition-scoped walk required |

## Verification
The only state is the response register and its valid bit. A wrong decode therefore appears in the response fields in the first cycle after the request is accepted. A register that is lost or overwritten during a stall appears as a changed field while rsp_ready is low. The bench models this expected register behaviourally on every clock. It compares valid, ready and all fields. It covers each quadrant in both modes, set and clear segment bits, both values of the top address bit in bypass, and random stall patterns.

// File: rtl/radix_ctx_pkg.sv
package radix_ctx_pkg;

  typedef enum logic [1:0] {
    QD_ZERO  = 2'd0,
    QD_ONE   = 2'd1,
    QD_TWO   = 2'd2,
    QD_THREE = 2'd3
  } quad_e;

  typedef struct packed {
    logic       fault;
    logic       bypass;
    logic       need_proc;
    logic       need_part;
    logic [2:0] perm;
  } ctx_flags_t;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/ctx_quad_map.sv
module ctx_quad_map
  import radix_ctx_pkg::*;
#(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic [1:0]        quad,
  input  logic              hv,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  output logic [LPID_W-1:0] lpid_sel,
  output logic [PID_W-1:0]  pid_sel,
  output logic              illegal
);

  quad_e q;
  assign q = quad_e'(quad);

  always_comb begin
    lpid_sel = '0;
    pid_sel  = '0;
    illegal  = 1'b0;
    if (hv) begin
      unique case (q)
        QD_ZERO:  begin lpid_sel = '0;       pid_sel = pid_reg; end
        QD_ONE:   begin lpid_sel = lpid_reg; pid_sel = pid_reg; end
        QD_TWO:   begin lpid_sel = lpid_reg; pid_sel = '0;      end
        QD_THREE: begin lpid_sel = '0;       pid_sel = '0;      end
        default:  begin lpid_sel = '0;       pid_sel = '0;      end
      endcase
    end else begin
      unique case (q)
        QD_ZERO:  begin lpid_sel = lpid_reg; pid_sel = pid_reg; end
        QD_THREE: begin lpid_sel = lpid_reg; pid_sel = '0;      end
        default:  illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ctx_realmode.sv
module ctx_realmode #(
  parameter int EA_W     = 64,
  parameter int CLR_BITS = 4
) (
  input  logic [EA_W-CLR_BITS-1:0] ea_low,
  input  logic                     ea_top,
  input  logic [EA_W-1:0]          rmo,
  output logic [EA_W-1:0]          raddr
);

  logic [EA_W-1:0] base;
  assign base  = EA_W'(ea_low);
  assign raddr = ea_top ? base : (base | rmo);

endmodule

// File: rtl/ctx_classify.sv
module ctx_classify
  import radix_ctx_pkg::*;
#(
  parameter int EA_W    = 64,
  parameter int VA_BITS = 52,
  parameter int LPID_W  = 12,
  parameter int PID_W   = 20
) (
  input  logic [EA_W-1:0]   ea,
  input  logic              hv,
  input  logic              reloc,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [EA_W-1:0]   rmo,
  output logic [LPID_W-1:0] lpid_o,
  output logic [PID_W-1:0]  pid_o,
  output logic [EA_W-1:0]   addr_o,
  output ctx_flags_t        flags_o
);

  localparam int SEG_HI   = EA_W - 3;
  localparam int CLR_BITS = 4;

  logic [LPID_W-1:0] lpid_q;
  logic [PID_W-1:0]  pid_q;
  logic              quad_bad;
  logic [EA_W-1:0]   rm_addr;
  logic              seg_nz, bypass, fault, pass;

  ctx_quad_map #(.LPID_W(LPID_W), .PID_W(PID_W)) u_qmap (
    .quad     (ea[EA_W-1:EA_W-2]),
    .hv       (hv),
    .lpid_reg (lpid_reg),
    .pid_reg  (pid_reg),
    .lpid_sel (lpid_q),
    .pid_sel  (pid_q),
    .illegal  (quad_bad)
  );

  ctx_realmode #(.EA_W(EA_W), .CLR_BITS(CLR_BITS)) u_rm (
    .ea_low (ea[EA_W-CLR_BITS-1:0]),
    .ea_top (ea[EA_W-1]),
    .rmo    (rmo),
    .raddr  (rm_addr)
  );

  assign seg_nz = |ea[SEG_HI:VA_BITS];
  assign bypass = hv & ~reloc;
  assign fault  = ~bypass & (seg_nz | quad_bad);
  assign pass   = ~bypass & ~fault;

  always_comb begin
    flags_o.fault     = fault;
    flags_o.bypass    = bypass;
    flags_o.need_proc = pass & reloc;
    flags_o.need_part = pass & ((lpid_q != '0) | ~hv);
    flags_o.perm      = bypass ? PERM_ALL : PERM_NONE;
    lpid_o            = pass ? lpid_q : '0;
    pid_o             = pass ? pid_q  : '0;
    addr_o            = bypass ? rm_addr : EA_W'(ea[VA_BITS-1:0]);
  end

endmodule

// File: rtl/ctx_hold_stage.sv
module ctx_hold_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R9: a stalled response must not move
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: an accepted request becomes a valid response next cycle
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/radix_ctx_sel.sv
module radix_ctx_sel
  import radix_ctx_pkg::*;
#(
  parameter int EA_W    = 64,
  parameter int VA_BITS = 52,
  parameter int LPID_W  = 12,
  parameter int PID_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [EA_W-1:0]   req_ea,
  input  logic              req_hv,
  input  logic              req_reloc,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [EA_W-1:0]   rmo_reg,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_seg_fault,
  output logic [LPID_W-1:0] rsp_lpid,
  output logic [PID_W-1:0]  rsp_pid,
  output logic              rsp_bypass,
  output logic [EA_W-1:0]   rsp_addr,
  output logic [2:0]        rsp_perm,
  output logic              rsp_need_proc,
  output logic              rsp_need_part
);

  localparam int FLG_W = $bits(ctx_flags_t);
  localparam int PAY_W = FLG_W + LPID_W + PID_W + EA_W;

  logic [LPID_W-1:0] c_lpid;
  logic [PID_W-1:0]  c_pid;
  logic [EA_W-1:0]   c_addr;
  ctx_flags_t        c_flags, r_flags;
  logic [PAY_W-1:0]  pay_in, pay_out;

  ctx_classify #(.EA_W(EA_W), .VA_BITS(VA_BITS), .LPID_W(LPID_W), .PID_W(PID_W)) u_cls (
    .ea       (req_ea),
    .hv       (req_hv),
    .reloc    (req_reloc),
    .lpid_reg (lpid_reg),
    .pid_reg  (pid_reg),
    .rmo      (rmo_reg),
    .lpid_o   (c_lpid),
    .pid_o    (c_pid),
    .addr_o   (c_addr),
    .flags_o  (c_flags)
  );

  assign pay_in = {c_flags, c_lpid, c_pid, c_addr};

  ctx_hold_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pay_out)
  );

  assign {r_flags, rsp_lpid, rsp_pid, rsp_addr} = pay_out;
  assign rsp_seg_fault = r_flags.fault;
  assign rsp_bypass    = r_flags.bypass;
  assign rsp_need_proc = r_flags.need_proc;
  assign rsp_need_part = r_flags.need_part;
  assign rsp_perm      = r_flags.perm;

  logic fire;
  assign fire = req_valid & req_ready;

  // R1: nonzero segment bits outside bypass fault next cycle
  p_segbits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (req_reloc || !req_hv) && (|req_ea[EA_W-3:VA_BITS]))
      |=> (rsp_valid && rsp_seg_fault));

  // R4: guest quadrants one and two are illegal
  p_guest_quad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_hv && (req_ea[EA_W-1] ^ req_ea[EA_W-2])) |=> rsp_seg_fault);

  // R4: a faulting response asks for no walk and carries no IDs
  p_fault_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_seg_fault)
      |-> (!rsp_need_proc && !rsp_need_part && rsp_lpid == '0 && rsp_pid == '0));

  // R5: hypervisor real-mode requests bypass with full permission
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_hv && !req_reloc)
      |=> (rsp_bypass && !rsp_seg_fault && rsp_perm == 3'b111));

  // R7: no process walk without relocation
  p_proc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_reloc) |=> !rsp_need_proc);

  // R6: guest requests that survive classification always need a partition walk
  p_part_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_hv && req_reloc && !(|req_ea[EA_W-3:VA_BITS])
      && (req_ea[EA_W-1] == req_ea[EA_W-2])) |=> rsp_need_part);

endmodule

// File: tb/radix_ctx_sel_bench.sv
`timescale 1ns/1ps
module radix_ctx_sel_bench;

  localparam int EA_W = 64, LPID_W = 12, PID_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [EA_W-1:0]   req_ea = '0;
  logic              req_hv = 1'b0, req_reloc = 1'b0;
  logic [LPID_W-1:0] lpid_reg = '0;
  logic [PID_W-1:0]  pid_reg = '0;
  logic [EA_W-1:0]   rmo_reg = '0;
  logic              rsp_valid, rsp_ready = 1'b1;
  logic              rsp_seg_fault, rsp_bypass, rsp_need_proc, rsp_need_part;
  logic [LPID_W-1:0] rsp_lpid;
  logic [PID_W-1:0]  rsp_pid;
  logic [EA_W-1:0]   rsp_addr;
  logic [2:0]        rsp_perm;

  radix_ctx_sel u_radix_ctx_sel (
    .clk, .rst_n, .req_valid, .req_ready, .req_ea, .req_hv, .req_reloc,
    .lpid_reg, .pid_reg, .rmo_reg, .rsp_valid, .rsp_ready, .rsp_seg_fault,
    .rsp_lpid, .rsp_pid, .rsp_bypass, .rsp_addr, .rsp_perm,
    .rsp_need_proc, .rsp_need_part
  );

  typedef struct {
    logic            v, fault, byp, np, nq;
    logic [11:0]     lp;
    logic [19:0]     pd;
    logic [63:0]     addr;
    logic [2:0]      perm;
  } exp_t;

  exp_t m;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic exp_t ref_eval(logic [63:0] ea, logic hv, logic rl,
                                    logic [11:0] lp, logic [19:0] pd, logic [63:0] rmo);
    exp_t e;
    logic [11:0] ls; logic [19:0] ps; logic bad;
    e = '{v:1, fault:0, byp:0, np:0, nq:0, lp:0, pd:0, addr:0, perm:0};
    if (hv && !rl) begin
      e.byp = 1; e.perm = 3'b111;
      e.addr = ea & 64'h0FFF_FFFF_FFFF_FFFF;
      if (!ea[63]) e.addr = e.addr | rmo;
      return e;
    end
    e.addr = ea & 64'h000F_FFFF_FFFF_FFFF;
    bad = (ea[61:52] != 0);
    ls = 0; ps = 0;
    if (hv) begin
      case (ea[63:62])
        2'd0: begin ls = 0;  ps = pd; end
        2'd1: begin ls = lp; ps = pd; end
        2'd2: begin ls = lp; ps = 0;  end
        default: begin ls = 0; ps = 0; end
      endcase
    end else begin
      case (ea[63:62])
        2'd0: begin ls = lp; ps = pd; end
        2'd3: begin ls = lp; ps = 0;  end
        default: bad = 1;
      endcase
    end
    if (bad) begin e.fault = 1; return e; end
    e.lp = ls; e.pd = ps; e.np = rl; e.nq = (ls != 0) || !hv;
    return e;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic v, logic [63:0] ea, logic hv, logic rl,
                      logic [11:0] lp, logic [19:0] pd, logic [63:0] rmo, logic rdy);
    @(negedge clk);
    req_valid = v; req_ea = ea; req_hv = hv; req_reloc = rl;
    lpid_reg = lp; pid_reg = pd; rmo_reg = rmo; rsp_ready = rdy;
    #1;
    chk("R9 ready", 64'(req_ready), 64'(!m.v || rdy));
    @(posedge clk); #1;
    if (m.v && !rdy) begin
    end else if (v) m = ref_eval(ea, hv, rl, lp, pd, rmo);
    else m.v = 0;
    chk("R8/R9 valid", 64'(rsp_valid), 64'(m.v));
    if (m.v) begin
      chk("R1/R4 fault", 64'(rsp_seg_fault), 64'(m.fault));
      chk("R2/R3 lpid", 64'(rsp_lpid), 64'(m.lp));
      chk("R2/R3 pid", 64'(rsp_pid), 64'(m.pd));
      chk("R5 bypass", 64'(rsp_bypass), 64'(m.byp));
      chk("R5/R7 addr", rsp_addr, m.addr);
      chk("R5 perm", 64'(rsp_perm), 64'(m.perm));
      chk("R7 need_proc", 64'(rsp_need_proc), 64'(m.np));
      chk("R6 need_part", 64'(rsp_need_part), 64'(m.nq));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [63:0] Q0 = 64'h0000_0000_0000_0000, Q1 = 64'h4000_0000_0000_0000,
                          Q2 = 64'h8000_0000_0000_0000, Q3 = 64'hC000_0000_0000_0000;

  initial begin
    m = '{v:0, fault:0, byp:0, np:0, nq:0, lp:0, pd:0, addr:0, perm:0};
    repeat (3) @(posedge clk);
    #1;
    chk("R10 valid", 64'(rsp_valid), 64'd0);
    chk("R10 ready", 64'(req_ready), 64'd1);
    @(negedge clk); rst_n = 1'b1;
    // R2 hypervisor quadrants
    for (int q = 0; q < 4; q++)
      step(1, (64'(q) << 62) | 64'h0_1234_5678_9ABC, 1, 1, 12'h05A, 20'h1_2345, 0, 1);
    // R2 quadrant 1 with partition register zero: no partition walk (R6)
    step(1, Q1 | 64'h777, 1, 1, 12'h000, 20'h00042, 0, 1);
    // R3/R4 guest quadrants
    for (int q = 0; q < 4; q++)
      step(1, (64'(q) << 62) | 64'h0_00FF_0000_1000, 0, 1, 12'h3C1, 20'hABCDE, 0, 1);
    // R1 segment bits, each end of the field
    step(1, Q0 | 64'h0010_0000_0000_0000, 0, 1, 12'h001, 20'h1, 0, 1);
    step(1, Q3 | 64'h2000_0000_0000_0000, 1, 1, 12'h001, 20'h1, 0, 1);
    // R1 segment bits ignored in bypass; R5 offset on ea[63]=0 vs 1
    step(1, Q1 | 64'h3FF0_0000_0000_0ABC, 1, 0, 12'h9, 20'h9, 64'hF000_0000_0100_0000, 1);
    step(1, Q2 | 64'h0000_0000_0000_0ABC, 1, 0, 12'h9, 20'h9, 64'hF000_0000_0100_0000, 1);
    // R7 guest with relocation off: partition walk only
    step(1, Q3 | 64'h000A_BCDE_F012_3456, 0, 0, 12'h044, 20'h5, 0, 1);
    // R9 stall: response must hold while new requests wait
    step(1, Q0 | 64'h55, 0, 1, 12'h011, 20'h22, 0, 0);
    step(1, Q3 | 64'h66, 0, 1, 12'h033, 20'h44, 0, 0);
    step(1, Q3 | 64'h66, 0, 1, 12'h033, 20'h44, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    // random traffic and stalls
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ea, rmo;
      logic [11:0] lp;
      ea  = {$urandom, $urandom};
      rmo = {$urandom, $urandom};
      if ($urandom_range(1, 0) == 0) ea[61:52] = '0;
      lp  = ($urandom_range(3, 0) == 0) ? 12'h0 : 12'($urandom);
      step($urandom_range(9, 0) < 8, ea, 1'($urandom), 1'($urandom), lp,
           20'($urandom), rmo, $urandom_range(9, 0) < 7);
    end
    finish_run();
  end

endmodule